// File: doc/BRIEF.md
# Hash Engine Control Register File

This block is the software-facing register file of a keyed-hash accelerator. A host reads and writes it over a simple word-wide register bus with a byte address, write data, byte strobes, a write enable, a read enable and read data. It drives the engine's configuration bits, its 256-bit key and one-cycle start and process commands. It collects done, FIFO-empty and error events into an interrupt line that can be masked and tested.

The engine reports a busy flag, a digest, the message length and its FIFO status. While the engine is busy, the configuration and key registers are frozen. A key write made during that time is dropped and reported as an error. The block holds the digest that the engine presents with its done pulse. Software reads the digest one word at a time, and each word can be returned byte-reversed. Clearing the hash-enable bit wipes the held digest.

Top module: `hcsr_top`

## Requirements
- R1: The interrupt state register at offset 0x00 holds done in bit 0, FIFO empty in bit 1 and error in bit 2. A `ev_done` or `ev_fifo_empty` pulse sets its bit at the next edge. Writing 1 to a bit with strobe 0 clears it. A set arriving in the same cycle as the clear wins.
- R2: The interrupt enable register at offset 0x04 (bits 2:0, written with strobe 0) masks the sources. `irq` equals the OR of (state AND enable), using the registers' current values.
- R3: A write to the test register at offset 0x08 with strobe 0 sets each state bit whose data bit is 1. This register reads as zero.
- R4: The configuration register at offset 0x0C holds keyed-mode enable (bit 0), hash enable (bit 1), input endian swap (bit 2) and digest swap (bit 3). It drives the four `cfg_*` outputs and reads back. A write made while `eng_busy` is 1 has no effect.
- R5: Key word i lives at offset 0x40+4*i, for i from 0 to 7. Each byte is written under its strobe. Word 0 forms `key_out[255:224]` and word 7 forms `key_out[31:0]`. Key words read as zero. A key write made while `eng_busy` is 1 leaves the key unchanged.
- R6: A key write made while busy sets the error-code register at offset 0x18 to 0x00000002. At the same edge it sets interrupt state bit 2. The code holds until reset.
- R7: Writing the command register at offset 0x10 with strobe 0 pulses `cmd_start` (data bit 0) and `cmd_process` (data bit 1) for exactly the following cycle. The register reads as zero.
- R8: The status register at offset 0x14 returns `fifo_empty_in` in bit 0, `fifo_full_in` in bit 1 and `fifo_level` in bits 8:4. All other bits read as zero.
- R9: A `ev_done` pulse while hash enable is 1 captures `digest_in`. Digest word i at offset 0x60+4*i returns `digest_in[255-32*i -: 32]`. When digest swap is 1, each word comes back byte-reversed.
- R10: At every edge where hash enable is 0, the held digest becomes all zeros.
- R11: `bus_rdata` updates one cycle after `bus_re`, and holds otherwise. The message length reads at 0x1C (bits 31:0) and 0x20 (bits 63:32). Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| eng_busy | input | 1 | Engine is computing |
| ev_done | input | 1 | Hash-done pulse |
| ev_fifo_empty | input | 1 | FIFO-became-empty pulse |
| fifo_empty_in | input | 1 | FIFO empty level |
| fifo_full_in | input | 1 | FIFO full level |
| fifo_level | input | 5 | FIFO entry count |
| digest_in | input | 256 | Engine digest |
| msg_len_in | input | 64 | Message length in bits |
| cfg_keyed_en | output | 1 | Keyed-mode enable |
| cfg_hash_en | output | 1 | Hash enable |
| cfg_endian_swap | output | 1 | Input endian swap |
| cfg_digest_swap | output | 1 | Digest byte swap |
| key_out | output | 256 | Assembled key |
| cmd_start | output | 1 | Start pulse |
| cmd_process | output | 1 | Process pulse |
| irq | output | 1 | Interrupt |

## Verification
The assertions check several properties on every cycle:
- the configuration and key registers stay frozen across busy cycles;
- a busy key write leaves the fixed error code;
- a test write always sets its bits;
- `irq` always matches the masked state;
- a low hash enable zeroes the digest;
- a command pulse always follows a bus write.

Some behaviour only the bench scenarios can show. These are the byte-strobe merging into key words, the key word order on `key_out`, and the per-word byte reversal of digest reads. The set-over-clear priority and the status bit layout are also covered only there. The bench compares every output against a behavioural model on every clock.

// File: rtl/hcsr_pkg.sv
package hcsr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CFG_W   = 4;
  localparam int unsigned IRQ_N   = 3;

  localparam int unsigned OFS_ISTATE = 'h00;
  localparam int unsigned OFS_IEN    = 'h04;
  localparam int unsigned OFS_ITEST  = 'h08;
  localparam int unsigned OFS_CFG    = 'h0C;
  localparam int unsigned OFS_CMD    = 'h10;
  localparam int unsigned OFS_STAT   = 'h14;
  localparam int unsigned OFS_ERR    = 'h18;
  localparam int unsigned OFS_LENLO  = 'h1C;
  localparam int unsigned OFS_LENHI  = 'h20;
  localparam int unsigned OFS_KEY    = 'h40;
  localparam int unsigned OFS_DIG    = 'h60;

  localparam logic [WORD_W-1:0] ERR_KEY_BUSY = 32'h0000_0002;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/hcsr_irq.sv
module hcsr_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic         test_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] state_q,
  output logic [N-1:0] en_q,
  output logic         irq_q
);
  logic [N-1:0] state_n, en_n;

  always_comb begin
    state_n = state_q;
    if (clr_wr)  state_n = state_n & ~wbits;
    state_n = state_n | hw_set;
    if (test_wr) state_n = state_n | wbits;
    en_n = en_wr ? wbits : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      en_q    <= en_n;
      irq_q   <= |(state_n & en_n);
    end
  end

  p_test_sets_r3: assert property (@(posedge clk) disable iff (rst)
    test_wr |=> ((state_q & $past(wbits)) == $past(wbits)));
  p_irq_tracks_r2: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(state_q & en_q));
endmodule

// File: rtl/hcsr_cfgkey.sv
module hcsr_cfgkey
  import hcsr_pkg::*;
#(
  parameter int unsigned KW = 8,
  localparam int unsigned KIDX_W = (KW > 1) ? $clog2(KW) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eng_busy,
  input  logic                 cfg_wr,
  input  logic                 key_wr,
  input  logic [KIDX_W-1:0]    key_idx,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [WORD_W/8-1:0]  be,
  output logic [CFG_W-1:0]     cfg_q,
  output logic [KW*WORD_W-1:0] key_flat,
  output logic                 key_err,
  output logic [WORD_W-1:0]    err_code
);
  logic [WORD_W-1:0] key_mem [KW];

  assign key_err = key_wr & eng_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      err_code <= '0;
    end else begin
      if (cfg_wr && !eng_busy && be[0]) cfg_q <= wdata[CFG_W-1:0];
      if (key_err) err_code <= ERR_KEY_BUSY;
    end
  end

  for (genvar w = 0; w < KW; w++) begin : g_word
    for (genvar b = 0; b < WORD_W/8; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) key_mem[w][8*b +: 8] <= '0;
        else if (key_wr && !eng_busy && be[b] && key_idx == KIDX_W'(w))
          key_mem[w][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    assign key_flat[(KW-1-w)*WORD_W +: WORD_W] = key_mem[w];
  end

  p_cfg_locked_r4: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> $stable(cfg_q));
  p_key_locked_r5: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> $stable(key_flat));
  p_err_code_r6: assert property (@(posedge clk) disable iff (rst)
    (key_wr && eng_busy) |=> (err_code == ERR_KEY_BUSY));
endmodule

// File: rtl/hcsr_digest.sv
module hcsr_digest #(
  parameter int unsigned DW = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hash_en,
  input  logic          capture,
  input  logic [DW-1:0] digest_in,
  output logic [DW-1:0] dig_q
);
  always_ff @(posedge clk) begin
    if (rst || !hash_en) dig_q <= '0;
    else if (capture)    dig_q <= digest_in;
  end

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !hash_en |=> (dig_q == '0));
endmodule

// File: rtl/hcsr_rdmux.sv
module hcsr_rdmux
  import hcsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DWORDS = 8,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned LEN_W  = 64
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [IRQ_N-1:0]         istate,
  input  logic [IRQ_N-1:0]         ien,
  input  logic [CFG_W-1:0]         cfg,
  input  logic                     f_empty,
  input  logic                     f_full,
  input  logic [LVL_W-1:0]         f_level,
  input  logic [WORD_W-1:0]        err_code,
  input  logic [LEN_W-1:0]         msg_len,
  input  logic [DWORDS*WORD_W-1:0] dig,
  output logic [WORD_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(OFS_ISTATE): rdata[IRQ_N-1:0] = istate;
      ADDR_W'(OFS_IEN):    rdata[IRQ_N-1:0] = ien;
      ADDR_W'(OFS_CFG):    rdata[CFG_W-1:0] = cfg;
      ADDR_W'(OFS_STAT):   rdata[4 +: LVL_W] = f_level;
      ADDR_W'(OFS_ERR):    rdata = err_code;
      ADDR_W'(OFS_LENLO):  rdata = msg_len[31:0];
      ADDR_W'(OFS_LENHI):  rdata = msg_len[63:32];
      default:             rdata = '0;
    endcase
    if (addr == ADDR_W'(OFS_STAT)) begin
      rdata[0] = f_empty;
      rdata[1] = f_full;
    end
    for (int i = 0; i < int'(DWORDS); i++) begin
      if (addr == ADDR_W'(OFS_DIG + 4*i)) begin
        rdata = cfg[3] ? byte_rev(dig[(DWORDS-1-i)*WORD_W +: WORD_W])
                       : dig[(DWORDS-1-i)*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/hcsr_top.sv
module hcsr_top
  import hcsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned KW     = 8,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned LEN_W  = 64,
  localparam int unsigned KIDX_W = (KW > 1) ? $clog2(KW) : 1,
  localparam int unsigned HW     = KW * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              eng_busy,
  input  logic              ev_done,
  input  logic              ev_fifo_empty,
  input  logic              fifo_empty_in,
  input  logic              fifo_full_in,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [HW-1:0]     digest_in,
  input  logic [LEN_W-1:0]  msg_len_in,
  output logic              cfg_keyed_en,
  output logic              cfg_hash_en,
  output logic              cfg_endian_swap,
  output logic              cfg_digest_swap,
  output logic [HW-1:0]     key_out,
  output logic              cmd_start,
  output logic              cmd_process,
  output logic              irq
);
  logic [IRQ_N-1:0]  istate, ien;
  logic [CFG_W-1:0]  cfg;
  logic              key_err;
  logic [WORD_W-1:0] err_code, rd_n;
  logic [HW-1:0]     dig;
  logic              key_hit, lane0;

  assign lane0   = bus_we & bus_be[0];
  assign key_hit = bus_we && (bus_addr[1:0] == 2'b00) &&
                   (bus_addr[ADDR_W-1:KIDX_W+2] == (ADDR_W-KIDX_W-2)'(OFS_KEY >> (KIDX_W+2)));

  hcsr_irq #(.N(IRQ_N)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .hw_set  ({key_err, ev_fifo_empty, ev_done}),
    .clr_wr  (lane0 && bus_addr == ADDR_W'(OFS_ISTATE)),
    .en_wr   (lane0 && bus_addr == ADDR_W'(OFS_IEN)),
    .test_wr (lane0 && bus_addr == ADDR_W'(OFS_ITEST)),
    .wbits   (bus_wdata[IRQ_N-1:0]),
    .state_q (istate),
    .en_q    (ien),
    .irq_q   (irq)
  );

  hcsr_cfgkey #(.KW(KW)) u_cfgkey (
    .clk      (clk),
    .rst      (rst),
    .eng_busy (eng_busy),
    .cfg_wr   (bus_we && bus_addr == ADDR_W'(OFS_CFG)),
    .key_wr   (key_hit),
    .key_idx  (bus_addr[KIDX_W+1:2]),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .cfg_q    (cfg),
    .key_flat (key_out),
    .key_err  (key_err),
    .err_code (err_code)
  );

  hcsr_digest #(.DW(HW)) u_digest (
    .clk       (clk),
    .rst       (rst),
    .hash_en   (cfg[1]),
    .capture   (ev_done),
    .digest_in (digest_in),
    .dig_q     (dig)
  );

  hcsr_rdmux #(.ADDR_W(ADDR_W), .DWORDS(KW), .LVL_W(LVL_W), .LEN_W(LEN_W)) u_rdmux (
    .addr     (bus_addr),
    .istate   (istate),
    .ien      (ien),
    .cfg      (cfg),
    .f_empty  (fifo_empty_in),
    .f_full   (fifo_full_in),
    .f_level  (fifo_level),
    .err_code (err_code),
    .msg_len  (msg_len_in),
    .dig      (dig),
    .rdata    (rd_n)
  );

  assign cfg_keyed_en    = cfg[0];
  assign cfg_hash_en     = cfg[1];
  assign cfg_endian_swap = cfg[2];
  assign cfg_digest_swap = cfg[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      cmd_start   <= 1'b0;
      cmd_process <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_n;
      cmd_start   <= lane0 && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[0];
      cmd_process <= lane0 && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[1];
    end
  end

  p_start_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_start || cmd_process) |-> $past(bus_we));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/tb_hcsr_top.sv
module tb_hcsr_top;
  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic [7:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0, bus_rdata;
  logic         bus_we = 0, bus_re = 0;
  logic [3:0]   bus_be = 0;
  logic         eng_busy = 0, ev_done = 0, ev_fifo_empty = 0;
  logic         fifo_empty_in = 1, fifo_full_in = 0;
  logic [4:0]   fifo_level = 0;
  logic [255:0] digest_in = 0, key_out;
  logic [63:0]  msg_len_in = 0;
  logic cfg_keyed_en, cfg_hash_en, cfg_endian_swap, cfg_digest_swap;
  logic cmd_start, cmd_process, irq;

  hcsr_top dut (.*);

  integer n_cmp = 0, n_bad = 0, cyc = 0;

  // behavioural reference
  logic [2:0]  m_st, m_en;
  logic [3:0]  m_cfg;
  logic [31:0] m_key [8];
  logic [31:0] m_dig [8];
  logic [31:0] m_err, m_rd;
  logic        m_rv, m_start, m_proc, m_irq;
  string       m_rtag;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return {29'b0, m_st};
    if (a == 8'h04) return {29'b0, m_en};
    if (a == 8'h0C) return {28'b0, m_cfg};
    if (a == 8'h14) return {23'b0, fifo_level, 2'b0, fifo_full_in, fifo_empty_in};
    if (a == 8'h18) return m_err;
    if (a == 8'h1C) return msg_len_in[31:0];
    if (a == 8'h20) return msg_len_in[63:32];
    if (a >= 8'h60 && a <= 8'h7C && a[1:0] == 0) begin
      logic [31:0] w;
      w = m_dig[(a - 8'h60) >> 2];
      return m_cfg[3] ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00) return "R1";
    if (a == 8'h04) return "R2";
    if (a == 8'h08) return "R3";
    if (a == 8'h0C) return "R4";
    if (a == 8'h10) return "R7";
    if (a == 8'h14) return "R8";
    if (a == 8'h18) return "R6";
    if (a >= 8'h40 && a < 8'h60) return "R5";
    if (a >= 8'h60 && a < 8'h80) return m_cfg[1] ? "R9" : "R10";
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_en = 0; m_cfg = 0; m_err = 0; m_rd = 0; m_rv = 0;
      m_start = 0; m_proc = 0; m_irq = 0;
      for (int i = 0; i < 8; i++) begin m_key[i] = 0; m_dig[i] = 0; end
    end else begin
      logic kw, kerr;
      m_rv = bus_re;
      if (bus_re) begin m_rd = m_read(bus_addr); m_rtag = tag_of(bus_addr); end
      m_start = bus_we && bus_be[0] && bus_addr == 8'h10 && bus_wdata[0];
      m_proc  = bus_we && bus_be[0] && bus_addr == 8'h10 && bus_wdata[1];
      kw   = bus_we && bus_addr >= 8'h40 && bus_addr < 8'h60 && bus_addr[1:0] == 0;
      kerr = kw && eng_busy;
      // digest uses hash enable before this edge
      if (!m_cfg[1]) for (int i = 0; i < 8; i++) m_dig[i] = 0;
      else if (ev_done) for (int i = 0; i < 8; i++) m_dig[i] = digest_in[255-32*i -: 32];
      if (kw && !eng_busy)
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) m_key[(bus_addr - 8'h40) >> 2][8*b +: 8] = bus_wdata[8*b +: 8];
      if (kerr) m_err = 32'h2;
      if (bus_we && bus_addr == 8'h0C && bus_be[0] && !eng_busy) m_cfg = bus_wdata[3:0];
      if (bus_we && bus_be[0] && bus_addr == 8'h00) m_st = m_st & ~bus_wdata[2:0];
      if (ev_done) m_st[0] = 1;
      if (ev_fifo_empty) m_st[1] = 1;
      if (kerr) m_st[2] = 1;
      if (bus_we && bus_be[0] && bus_addr == 8'h08) m_st = m_st | bus_wdata[2:0];
      if (bus_we && bus_be[0] && bus_addr == 8'h04) m_en = bus_wdata[2:0];
      m_irq = |(m_st & m_en);
    end
  end

  task automatic cmp(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      logic [255:0] mk;
      for (int i = 0; i < 8; i++) mk[255-32*i -: 32] = m_key[i];
      cmp("R2 irq", {255'b0, irq}, {255'b0, m_irq});
      cmp("R4 cfg", {252'b0, cfg_digest_swap, cfg_endian_swap, cfg_hash_en, cfg_keyed_en},
          {252'b0, m_cfg});
      cmp("R5 key_out", key_out, mk);
      cmp("R7 cmd", {254'b0, cmd_process, cmd_start}, {254'b0, m_proc, m_start});
      if (m_rv) cmp({m_rtag, " rdata"}, {224'b0, bus_rdata}, {224'b0, m_rd});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic pulse_done();
    ev_done = 1; @(negedge clk); ev_done = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    // reset state
    rd(8'h14); rd(8'h00); rd(8'h18); rd(8'h0C);
    // R4 configuration and lock
    wr(8'h0C, 32'hFFFF_FFFF, 4'hF); rd(8'h0C);
    eng_busy = 1;
    wr(8'h0C, 32'h0, 4'hF); rd(8'h0C);
    eng_busy = 0;
    wr(8'h0C, 32'h5, 4'hE); rd(8'h0C);   // strobe 0 off: ignored
    wr(8'h0C, 32'h3, 4'h1); rd(8'h0C);
    // R5 keys
    for (int i = 0; i < 8; i++) wr(8'h40 + 8'(4*i), 32'h1111_1111 * (i + 1), 4'hF);
    wr(8'h44, 32'hAABB_CCDD, 4'b0101);
    rd(8'h40); rd(8'h5C);
    // R6 busy key write
    wr(8'h04, 32'h7, 4'h1);
    eng_busy = 1;
    wr(8'h48, 32'hDEAD_BEEF, 4'hF);
    tick(1);
    eng_busy = 0;
    rd(8'h18); rd(8'h00);
    // R1 clear, set-over-clear
    wr(8'h00, 32'h4, 4'h1); rd(8'h00);
    ev_fifo_empty = 1; wr(8'h00, 32'h2, 4'h1); ev_fifo_empty = 0; rd(8'h00);
    wr(8'h00, 32'h7, 4'h1); rd(8'h00);
    // R3 test register
    wr(8'h08, 32'h5, 4'h1); rd(8'h00); rd(8'h08);
    wr(8'h04, 32'h2, 4'h1); wr(8'h00, 32'h7, 4'h1); rd(8'h04);
    // R9 digest
    for (int i = 0; i < 8; i++) digest_in[255-32*i -: 32] = 32'h0102_0304 + 32'h1010_1010 * i;
    pulse_done();
    digest_in = '1;
    for (int i = 0; i < 8; i++) rd(8'h60 + 8'(4*i));
    wr(8'h0C, 32'hA, 4'h1);
    for (int i = 0; i < 8; i++) rd(8'h60 + 8'(4*i));
    // R10 clearing hash enable
    wr(8'h0C, 32'h8, 4'h1); tick(1);
    rd(8'h60); rd(8'h7C);
    pulse_done(); rd(8'h64);
    // R7 commands
    wr(8'h10, 32'h1, 4'h1); tick(1);
    wr(8'h10, 32'h2, 4'h1); tick(1);
    wr(8'h10, 32'h3, 4'h1); wr(8'h10, 32'h3, 4'h2); rd(8'h10);
    // R8 status, R11 length and unmapped
    fifo_empty_in = 0; fifo_full_in = 1; fifo_level = 5'd16; rd(8'h14);
    fifo_full_in = 0; fifo_level = 5'd31; rd(8'h14);
    msg_len_in = 64'h0123_4567_89AB_CDE8; rd(8'h1C); rd(8'h20);
    rd(8'h30); rd(8'h62); tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule